// File: doc/BRIEF.md
# Single-Wire Pulse-Count Level Programmer

This block sits beside a dual-rail display power controller and interprets its one control wire. Driving the wire high switches the controller on. After a power-up settling interval, the host may send a burst of short low/high pulses. The block counts their rising edges and, once the wire has rested high for a storage interval, commits the count as a 5-bit setpoint code for the negative rail. It also commits the matching value in millivolts.

A plain enable with no pulses commits the default code 0, which stands for −4000 mV. A low level held longer than the shutdown interval is not a pulse: it switches the controller off and puts the stored setpoint back to its default. A fresh pulse burst after a commit starts a new count, and that count replaces the old code. All intervals are parameters in microseconds, converted to clock cycles from a clock frequency parameter. The control wire passes through a synchroniser before any edge is seen.

Top module: `pulse_level_prog`

## Requirements
- R1: During and right after reset, `enable` is 0, `setpointCode` is 0, `setpointMv` is −4000 and `codeValid` is 0.
- R2: A rising level on `ctrlLine` while the block is off sets `enable` to 1 within four clock cycles.
- R3: An enable with no following pulses commits code 0 with `setpointMv` = −4000, marked by exactly one `codeValid` strobe.
- R4: n counted rising edges, with n from 1 to 31, commit code n with `setpointMv` = −4400 + 100·(n−1). For example, 1 gives −4400, 3 gives −4200 and 31 gives −1400.
- R5: A count above 31 saturates, committing code 31 and −1400 mV.
- R6: Rising edges that arrive before the initialisation interval (INIT_US after the enabling edge) has elapsed are not counted and do not produce a commit.
- R7: A commit happens only after the line has stayed high for STORE_US since the last counted rising edge: there is no strobe 20 cycles before that point, and there is one within 20 cycles after it.
- R8: A low shorter than OFF_US keeps `enable` at 1. A low of OFF_US or longer drops `enable` and restores code 0 and −4000 mV, with one `codeValid` strobe.
- R9: `codeValid` never lasts more than one cycle, and `setpointMv` changes only in a cycle where `codeValid` is 1.
- R10: A new pulse burst after a commit starts counting from zero. A burst of 3 followed by a burst of 2 commits code 2.
- R11: After a disable, enabling again restarts the whole sequence, and a later burst of 4 commits code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock of frequency CLK_HZ |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlLine | input | 1 | Asynchronous shared enable / pulse-programming wire |
| enable | output | 1 | Controller enabled |
| setpointCode | output | 5 | Committed edge-count code, 0 meaning default |
| setpointMv | output | 16 | Committed negative setpoint in millivolts, two's complement |
| codeValid | output | 1 | One-cycle strobe for each commit or restore |

## Verification
The hardest situation to reach from the ports is a pulse that falls inside the initialisation window but after the default commit has already happened. In that case, the only visible evidence of correct behaviour is that nothing happens. The bench enables the block and lets the default commit go by. It then sends one full pulse while the window is still open, and it watches for the absence of any strobe across a full storage interval. Finally, it sends a real burst after the window and confirms that the committed code counts only the later edges. The timing windows around the storage interval and the shutdown interval are probed 20 cycles on either side of their nominal end.

// File: rtl/plp_pkg.sv
package plp_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } plpState_e;

  // Strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic clearCnt;   // enabling edge: start a fresh count
    logic countEdge;  // a programming rising edge was seen
    logic commit;     // high-hold interval elapsed: latch the count
    logic restore;    // shutdown low detected: back to default
  } plpStrobe_t;

endpackage

// File: rtl/plp_ctrl.sv
module plp_ctrl
  import plp_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int INIT_US     = 400,
  parameter int STORE_US    = 55,
  parameter int OFF_US      = 55,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlIn,
  output logic       enable,
  output plpStrobe_t strobe
);

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int INIT_RAW   = CYC_PER_MS * INIT_US / 1000;
  localparam int STORE_RAW  = CYC_PER_MS * STORE_US / 1000;
  localparam int OFF_RAW    = CYC_PER_MS * OFF_US / 1000;
  localparam int INIT_CYC   = (INIT_RAW  < 2) ? 2 : INIT_RAW;
  localparam int STORE_CYC  = (STORE_RAW < 2) ? 2 : STORE_RAW;
  localparam int OFF_CYC    = (OFF_RAW   < 2) ? 2 : OFF_RAW;
  localparam int MAX_A      = (INIT_CYC > STORE_CYC) ? INIT_CYC : STORE_CYC;
  localparam int MAX_CYC    = (MAX_A > OFF_CYC) ? MAX_A : OFF_CYC;
  localparam int TMR_W      = $clog2(MAX_CYC + 1);
  localparam int SYNC_N     = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  localparam logic [TMR_W-1:0] INIT_LAST  = TMR_W'(INIT_CYC - 1);
  localparam logic [TMR_W-1:0] STORE_LAST = TMR_W'(STORE_CYC - 1);
  localparam logic [TMR_W-1:0] OFF_LAST   = TMR_W'(OFF_CYC - 1);

  logic [SYNC_N-1:0] syncQ;
  logic              lineD;
  logic              lineNow;
  logic              rise;

  plpState_e        stQ;
  logic [TMR_W-1:0] initCnt;
  logic [TMR_W-1:0] lowCnt;
  logic [TMR_W-1:0] hiCnt;
  logic             pending;

  // Synchroniser chain, depth chosen by parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lineD <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_N-2:0], ctrlIn};
      lineD <= syncQ[SYNC_N-1];
    end
  end

  assign lineNow = syncQ[SYNC_N-1];
  assign rise    = lineNow & ~lineD;

  always_comb begin
    strobe = '0;
    if (stQ == ST_OFF) begin
      strobe.clearCnt = rise;
    end else if (!lineNow && lowCnt == OFF_LAST) begin
      strobe.restore = 1'b1;
    end else if (rise && stQ == ST_RUN) begin
      strobe.countEdge = 1'b1;
    end else if (lineNow && !rise && pending && hiCnt == STORE_LAST) begin
      strobe.commit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_OFF;
      initCnt <= '0;
      lowCnt  <= '0;
      hiCnt   <= '0;
      pending <= 1'b0;
    end else if (stQ == ST_OFF) begin
      if (rise) begin
        stQ     <= ST_INIT;
        initCnt <= '0;
        lowCnt  <= '0;
        hiCnt   <= TMR_W'(1);
        pending <= 1'b1;
      end
    end else begin
      if (stQ == ST_INIT) begin
        if (initCnt == INIT_LAST) stQ <= ST_RUN;
        else                      initCnt <= initCnt + 1'b1;
      end
      if (lineNow) begin
        lowCnt <= '0;
        if (rise) begin
          hiCnt <= TMR_W'(1);
          if (stQ == ST_RUN) pending <= 1'b1;
        end else if (hiCnt != STORE_LAST) begin
          hiCnt <= hiCnt + 1'b1;
        end
        if (strobe.commit) pending <= 1'b0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
      if (strobe.restore) begin
        stQ     <= ST_OFF;
        pending <= 1'b0;
        lowCnt  <= '0;
      end
    end
  end

  assign enable = (stQ != ST_OFF);

endmodule

// File: rtl/plp_datapath.sv
module plp_datapath
  import plp_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int MV_W       = 16,
  parameter int DEFAULT_MV = -4000,
  parameter int FIRST_MV   = -4400,
  parameter int STEP_MV    = 100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  plpStrobe_t             strobe,
  output logic [CODE_W-1:0]      codeQ,
  output logic signed [MV_W-1:0] mvQ,
  output logic                   validQ
);

  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] edgeCnt;

  function automatic logic signed [MV_W-1:0] codeToMv(input logic [CODE_W-1:0] c);
    if (c == '0) return MV_W'(DEFAULT_MV);
    return MV_W'(FIRST_MV + STEP_MV * (int'(c) - 1));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      codeQ   <= '0;
      mvQ     <= MV_W'(DEFAULT_MV);
      validQ  <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (strobe.restore) begin
        edgeCnt <= '0;
        codeQ   <= '0;
        mvQ     <= MV_W'(DEFAULT_MV);
        validQ  <= 1'b1;
      end else if (strobe.commit) begin
        codeQ   <= edgeCnt;
        mvQ     <= codeToMv(edgeCnt);
        validQ  <= 1'b1;
        edgeCnt <= '0;
      end else if (strobe.clearCnt) begin
        edgeCnt <= '0;
      end else if (strobe.countEdge && edgeCnt != MAX_CODE) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pulse_level_prog.sv
module pulse_level_prog
  import plp_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int INIT_US     = 400,
  parameter int STORE_US    = 55,
  parameter int OFF_US      = 55,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 5,
  parameter int MV_W        = 16,
  parameter int DEFAULT_MV  = -4000,
  parameter int FIRST_MV    = -4400,
  parameter int STEP_MV     = 100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctrlLine,
  output logic                   enable,
  output logic [CODE_W-1:0]      setpointCode,
  output logic signed [MV_W-1:0] setpointMv,
  output logic                   codeValid
);

  plpStrobe_t strobe;

  plp_ctrl #(
    .CLK_HZ(CLK_HZ), .INIT_US(INIT_US), .STORE_US(STORE_US),
    .OFF_US(OFF_US), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlLine),
    .enable(enable), .strobe(strobe)
  );

  plp_datapath #(
    .CODE_W(CODE_W), .MV_W(MV_W), .DEFAULT_MV(DEFAULT_MV),
    .FIRST_MV(FIRST_MV), .STEP_MV(STEP_MV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .codeQ(setpointCode), .mvQ(setpointMv), .validQ(codeValid)
  );

endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
  parameter int CODE_W     = 5,
  parameter int MV_W       = 16,
  parameter int DEFAULT_MV = -4000,
  parameter int FIRST_MV   = -4400,
  parameter int STEP_MV    = 100
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   enable,
  input logic [CODE_W-1:0]      setpointCode,
  input logic signed [MV_W-1:0] setpointMv,
  input logic                   codeValid
);

  p_mv_only_on_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (setpointMv != $past(setpointMv)) |-> codeValid);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid);

  p_restore_default_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> (codeValid && setpointCode == '0
                       && setpointMv == MV_W'(DEFAULT_MV)));

  p_code_mv_map_r4: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && setpointCode != '0) |->
      (setpointMv == MV_W'(FIRST_MV + STEP_MV * (int'(setpointCode) - 1))));

  p_default_map_r3: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && setpointCode == '0) |-> (setpointMv == MV_W'(DEFAULT_MV)));

  p_valid_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !enable) |-> $fell(enable));

endmodule

bind pulse_level_prog plp_checker #(
  .CODE_W(CODE_W), .MV_W(MV_W), .DEFAULT_MV(DEFAULT_MV),
  .FIRST_MV(FIRST_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .setpointCode(setpointCode),
  .setpointMv(setpointMv), .codeValid(codeValid)
);

// File: tb/pulse_level_prog_tb.sv
`timescale 1ns/1ps
module pulse_level_prog_tb;

  // 10 MHz timing base inside the DUT: 10 cycles per microsecond
  localparam int DUT_HZ    = 10_000_000;
  localparam int STORE_CYC = 550;   // 55 us
  localparam int OFF_CYC   = 550;   // 55 us
  localparam int INIT_CYC  = 4000;  // 400 us
  localparam int PW        = 100;   // 10 us pulse phases

  logic              clk = 1'b0;
  logic              rstN;
  logic              ctrlLine;
  logic              enable;
  logic [4:0]        setpointCode;
  logic signed [15:0] setpointMv;
  logic              codeValid;

  int checkCnt = 0;
  int failCnt  = 0;
  int validCnt = 0;
  int multiErr = 0;
  int chgErr   = 0;
  bit prevValid = 1'b0;
  logic signed [15:0] prevMv = -16'sd4000;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pulse_level_prog #(
    .CLK_HZ(DUT_HZ), .INIT_US(400), .STORE_US(55), .OFF_US(55)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ctrlLine(ctrlLine), .enable(enable),
    .setpointCode(setpointCode), .setpointMv(setpointMv), .codeValid(codeValid)
  );

  // Output monitor away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (codeValid) validCnt++;
      if (codeValid && prevValid) multiErr++;
      if (setpointMv != prevMv && !codeValid) chgErr++;
    end
    prevValid = codeValid;
    prevMv    = setpointMv;
  end

  function automatic int expMv(input int n);
    if (n == 0) return -4000;
    return -4400 + 100 * (n - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lowC, input int highC);
    ctrlLine = 1'b0;
    hold(lowC);
    ctrlLine = 1'b1;
    hold(highC);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  task automatic t_reset();
    ctrlLine = 1'b0;
    rstN = 1'b0;
    hold(5);
    check(enable == 1'b0, "R1 enable", int'(enable), 0);
    check(setpointCode == 5'd0, "R1 code", int'(setpointCode), 0);
    check(int'(setpointMv) == -4000, "R1 mv", int'(setpointMv), -4000);
    check(codeValid == 1'b0, "R1 valid", int'(codeValid), 0);
    rstN = 1'b1;
    hold(5);
    check(enable == 1'b0 && codeValid == 1'b0, "R1 after release", int'(enable), 0);
  endtask

  task automatic t_plainEnable(input string tag);
    int vb;
    vb = validCnt;
    ctrlLine = 1'b1;
    hold(4);
    check(enable == 1'b1, {tag, " enable rises"}, int'(enable), 1);
    hold(STORE_CYC - 24);
    check(validCnt == vb, "R7 no early default commit", validCnt - vb, 0);
    hold(40);
    check(validCnt == vb + 1, "R3 one default strobe", validCnt - vb, 1);
    check(setpointCode == 5'd0, "R3 default code", int'(setpointCode), 0);
    check(int'(setpointMv) == -4000, "R3 default mv", int'(setpointMv), -4000);
  endtask

  task automatic t_initIgnored();
    int vb;
    vb = validCnt;
    pulse(PW, PW);
    hold(STORE_CYC + 150);
    check(validCnt == vb, "R6 pulse in init gives no commit", validCnt - vb, 0);
    check(setpointCode == 5'd0, "R6 code untouched", int'(setpointCode), 0);
    hold(INIT_CYC);
  endtask

  task automatic t_program(input int n, input int lowC, input int expCode, input string req);
    int vb;
    vb = validCnt;
    for (int i = 0; i < n; i++) pulse(lowC, PW);
    hold(STORE_CYC - PW - 20);
    check(validCnt == vb, "R7 no commit before hold", validCnt - vb, 0);
    hold(40);
    check(validCnt == vb + 1, "R7 commit after hold", validCnt - vb, 1);
    check(int'(setpointCode) == expCode, {req, " code"}, int'(setpointCode), expCode);
    check(int'(setpointMv) == expMv(expCode), {req, " mv"}, int'(setpointMv), expMv(expCode));
    check(enable == 1'b1, {req, " stays enabled"}, int'(enable), 1);
  endtask

  task automatic t_disable();
    int vb;
    vb = validCnt;
    ctrlLine = 1'b0;
    hold(OFF_CYC - 20);
    check(enable == 1'b1, "R8 short of shutdown", int'(enable), 1);
    hold(40);
    check(enable == 1'b0, "R8 disabled", int'(enable), 0);
    check(validCnt == vb + 1, "R8 restore strobe", validCnt - vb, 1);
    check(setpointCode == 5'd0, "R8 code default", int'(setpointCode), 0);
    check(int'(setpointMv) == -4000, "R8 mv default", int'(setpointMv), -4000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    t_reset();
    t_plainEnable("R2");
    t_initIgnored();
    t_program(3, PW, 3, "R4");
    t_program(2, PW, 2, "R10");
    t_program(1, PW, 1, "R4");
    t_program(5, PW, 5, "R4");
    t_program(31, PW, 31, "R4");
    t_program(35, PW, 31, "R5");
    t_program(2, 250, 2, "R8");
    t_disable();
    t_plainEnable("R11");
    hold(INIT_CYC);
    t_program(4, PW, 4, "R11");
    check(multiErr == 0, "R9 strobe width", multiErr, 0);
    check(chgErr == 0, "R9 mv change without strobe", chgErr, 0);
    finished = 1'b1;
    summary();
  end

endmodule